// File: doc/BRIEF.md
# Two-Stage Sensed SRAM Bank Controller

This block holds a 256-word by 32-bit single-port memory bank and runs its reads in two clock cycles. In the first cycle it registers the address and raises the wordline strobe. That is the window in which the bitlines develop their differential. At the next rising edge the sense strobe fires and the word is resolved. The word is presented with a valid flag for the whole of that second cycle.

Because the sense step of one read overlaps the droop step of the next, a new read can be accepted on every clock. The fixed latency is two cycles and throughput is one word per cycle. A write takes one request slot and lands in the array at the edge that accepts it. A read issued in the very next slot therefore sees the new word.

The block takes one request per cycle on a single port. Both strobes are brought out so that the analog sense path can be timed against them.

Top module: `sram_pipe_rd`

## Requirements
- R1: Every one of the 256 words (addresses 0 to 255) stores a full 32-bit value. A read returns the value most recently written at that address.
- R2: A read accepted at a rising edge (req_en=1, req_wr=0) raises wl_en for the single cycle that follows that edge. wl_en is high in no other cycle.
- R3: sa_en is high exactly in the cycle after a cycle with wl_en high, and in no other cycle. The sensed word is taken only from a read whose wordline was raised.
- R4: rd_valid is high, with rd_data holding the requested word, in the second cycle after the edge that accepted the read. Reads accepted on consecutive edges give rd_valid on consecutive cycles.
- R5: A write (req_en=1, req_wr=1) or an idle slot (req_en=0) raises neither wl_en nor, one cycle later, sa_en.
- R6: While rd_valid is low, rd_data keeps the last word delivered. After reset it holds zero.
- R7: A read issued in the slot right after a write to the same address returns the new word. A read issued in the slot right before a write to its address returns the old word.
- R8: While rst_n is low at a rising edge, all in-flight reads are dropped. wl_en, sa_en and rd_valid are low and rd_data is zero in the following cycle. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_en | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| wl_en | output | 1 | Wordline strobe, high during the droop cycle of a read |
| sa_en | output | 1 | Sense strobe, high during the resolve cycle of a read |
| rd_data | output | 32 | Sensed word |
| rd_valid | output | 1 | rd_data carries a fresh read result |

## Verification
The properties assume that reset is held low for at least three clock edges, so every checked signal has a defined past value once checking begins. They also assume that req_en, req_wr and req_addr are stable around each rising edge. The stimulus changes inputs only on falling edges and holds reset for three edges at start-up and at the mid-run reset. It writes every address before any read, so no read returns an unwritten word.

// File: rtl/sram_pipe_rd.sv
module sram_pipe_rd #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_en,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          wl_en,
  output logic          sa_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic [DW-1:0] bank [WORDS];
  logic          droop_v;
  logic          sense_v;
  logic [AW-1:0] droop_a;
  logic [DW-1:0] sense_q;

  wire rd_req = req_en && !req_wr;
  wire wr_req = req_en && req_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      droop_v <= 1'b0;
      sense_v <= 1'b0;
      sense_q <= '0;
    end else begin
      droop_v <= rd_req;
      sense_v <= droop_v;
      if (droop_v) sense_q <= bank[droop_a];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req) droop_a <= req_addr;
    if (wr_req) bank[req_addr] <= req_wdata;
  end

  assign wl_en    = droop_v;
  assign sa_en    = sense_v;
  assign rd_valid = sense_v;
  assign rd_data  = sense_q;

endmodule

// File: rtl/sram_pipe_rd_chk.sv
module sram_pipe_rd_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_en,
  input logic          req_wr,
  input logic [AW-1:0] req_addr,
  input logic          wl_en,
  input logic          sa_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid
);

  AST_WL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) (req_en && !req_wr) |=> wl_en); // R2
  AST_WL_ONLY_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) wl_en |-> $past(req_en && !req_wr)); // R2
  AST_SENSE_AFTER_WL: assert property (@(posedge clk) disable iff (!rst_n) wl_en |=> sa_en); // R3
  AST_SENSE_NEEDS_WL: assert property (@(posedge clk) disable iff (!rst_n) sa_en |-> $past(wl_en)); // R3
  AST_READ_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n) (req_en && !req_wr) |-> ##2 rd_valid); // R4
  AST_WRITE_NO_WL: assert property (@(posedge clk) disable iff (!rst_n) (req_en && req_wr) |=> !wl_en); // R5
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |-> $stable(rd_data)); // R6

endmodule

bind sram_pipe_rd sram_pipe_rd_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr), .req_addr(req_addr),
  .wl_en(wl_en), .sa_en(sa_en), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/sram_pipe_rd_tb.sv
`timescale 1ns/1ps
module sram_pipe_rd_tb;
  localparam int WORDS = 256;
  localparam int DW    = 32;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_en = 1'b0;
  logic          req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          wl_en, sa_en, rd_valid;
  logic [DW-1:0] rd_data;

  sram_pipe_rd #(.WORDS(WORDS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .wl_en(wl_en), .sa_en(sa_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: per-cycle expectation maps
  logic [DW-1:0] mem_m [WORDS];
  bit            wl_map [int];
  logic [DW-1:0] dat_map [int];
  string         tag_map [int];
  int            cyc = 0;
  bit            in_rst = 1;
  bit            prev_wr = 0;
  logic [AW-1:0] prev_a = '0;
  logic [DW-1:0] last_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      in_rst = 1;
      wl_map.delete();
      dat_map.delete();
      tag_map.delete();
      last_data = '0;
      prev_wr = 0;
    end else begin
      in_rst = 0;
      cyc++;
      if (req_en && !req_wr) begin
        wl_map[cyc] = 1;
        dat_map[cyc+1] = mem_m[req_addr];
        if (prev_wr && prev_a == req_addr) tag_map[cyc+1] = "R7";
        else if (req_addr == 0 || req_addr == AW'(WORDS-1)) tag_map[cyc+1] = "R1";
        else tag_map[cyc+1] = "R4";
      end
      prev_wr = req_en && req_wr;
      prev_a  = req_addr;
      if (req_en && req_wr) mem_m[req_addr] = req_wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (in_rst) begin
        chk("R8", DW'(wl_en), '0);
        chk("R8", DW'(sa_en), '0);
        chk("R8", DW'(rd_valid), '0);
        chk("R8", rd_data, '0);
      end else begin
        bit ew, es;
        ew = wl_map.exists(cyc);
        es = dat_map.exists(cyc);
        chk(ew ? "R2" : "R5", DW'(wl_en), DW'(ew));
        chk("R3", DW'(sa_en), DW'(es));
        chk("R4", DW'(rd_valid), DW'(es));
        if (es) begin
          chk(tag_map[cyc], rd_data, dat_map[cyc]);
          last_data = dat_map[cyc];
        end else begin
          chk("R6", rd_data, last_data);
        end
      end
    end
  end

  task automatic op(bit en, bit wr, int a, logic [DW-1:0] d);
    @(negedge clk);
    req_en = en; req_wr = wr; req_addr = AW'(a); req_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, '0);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: fill every word
    for (int a = 0; a < WORDS; a++) op(1, 1, a, (32'h9E3779B9 * a) ^ 32'h5A5A0000);
    // R4: back-to-back reads over the whole bank
    for (int a = 0; a < WORDS; a++) op(1, 0, a, '0);
    idle(3);
    // R1 boundaries, all-ones and zero patterns
    op(1, 1, 0, 32'hFFFFFFFF); op(1, 1, WORDS-1, 32'h00000000);
    op(1, 0, WORDS-1, '0); op(1, 0, 0, '0);
    idle(2);
    // R7: write then read same address in next slot
    for (int i = 0; i < 16; i++) begin
      op(1, 1, i * 13 + 7, 32'hC0DE0000 + i);
      op(1, 0, i * 13 + 7, '0);
    end
    // R7: read then write same address; later read sees new
    for (int i = 0; i < 8; i++) begin
      op(1, 0, 40 + i, '0);
      op(1, 1, 40 + i, 32'hBEEF0000 ^ i);
      op(1, 0, 40 + i, '0);
    end
    // R6: isolated reads with idle gaps
    for (int i = 0; i < 10; i++) begin
      op(1, 0, 200 + i, '0);
      idle(i % 3 + 1);
    end
    // R8: reset with reads in flight, then contents still there
    op(1, 0, 5, '0); op(1, 0, 6, '0);
    @(negedge clk);
    rst_n = 0; req_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) op(1, 0, a, '0);
    op(1, 1, 3, 32'h12345678); op(0, 0, 0, '0); op(1, 0, 3, '0);
    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule